// File: doc/BRIEF.md
# Octet Slip Buffer with Time-Slot Serial Output

This block sits between a 64 kbit/s codirectional receiver and a 2.048 Mbit/s PCM highway. Whole octets arrive from the line side at a pace set by the far-end transmitter, each marked by a one-cycle strobe on the write clock. The block stores them in a small ring and hands them out as eight-bit bursts inside a time slot. The local 2.048 MHz read clock defines that slot, and the two clocks need not be related.

The write pointer crosses into the read domain in Gray code through a synchronizer chain. The read side compares it with its own pointer once per slot, at the first cycle of the slot, and picks one of three actions. With one or two unread octets it sends the oldest one. With none unread, because the local clock runs fast, it sends the previous octet again. With three or more unread, because the local clock runs slow, it drops the oldest octet and sends the next one. Slips always move by whole octets, so bit alignment inside an octet never shifts.

Two time-slot inputs are present, and a select input picks the one that frames the output. The serial output comes straight from a flip-flop and sits at logic high whenever no octet is being shifted out.

Top module: `osb_top`

## Requirements
- R1: After reset (read-side reset held low) `ser_out` is 1. The repeat octet is 8'hFF, so a slot that finds the ring empty right after reset sends 8'hFF.
- R2: Whenever the selected time-slot signal is low at a read clock edge, `ser_out` is 1 after that edge.
- R3: A slot begins at the first read clock edge where the selected time-slot signal is high after being low. From that edge on, `ser_out` gives the chosen octet MSB first, one bit per edge, for 8 edges. Any further edges with the slot still high give 1.
- R4: With `ts_sel` = 1 the slot is framed by `ts_a`, and with `ts_sel` = 0 by `ts_b`. Pulses on the unselected line leave `ser_out` at 1 and consume no octet.
- R5: When the number of unread octets at slot start is 1 or 2 (with the default depth of 4), the oldest unread octet is sent and removed. Octets go out in the order they were written.
- R6: When no octet is unread at slot start, the octet sent in the previous slot is sent again and nothing is removed.
- R7: When DEPTH-1 (3 by default) or more octets are unread at slot start, the oldest is discarded and the next-oldest is sent, so two octets are removed.
- R8: The read pointer moves only at slot start. A write during a slot does not alter the octet being shifted out.
- R9: The write pointer passed to the read domain changes in at most one bit per write clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock (line recovered timing) |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_stb | input | 1 | One-cycle strobe: `wr_octet` holds a complete octet |
| wr_octet | input | 8 | Received octet, bit 7 first on the line |
| rd_clk | input | 1 | Local 2.048 MHz read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| ts_a | input | 1 | First time-slot signal, high during the slot |
| ts_b | input | 1 | Second time-slot signal, high during the slot |
| ts_sel | input | 1 | 1 selects `ts_a`, 0 selects `ts_b` |
| ser_out | output | 1 | Serial data, MSB first within the slot, 1 when idle |

## Verification
The checker watches the read pointer on every read cycle. It confirms that the pointer holds still except at slot start and moves by 0, 1 or 2 depending on the fill seen at that moment. It also checks that idle cycles drive a high output and that each write moves the Gray pointer by a single bit. Whether the right octet value comes out, in MSB-first order and after the right slip, can only be shown by the bench. The bench compares each serial bit against an octet history it keeps itself, across random write counts per frame, alternating slot select and noise on the unselected slot line.

// File: rtl/osb_pkg.sv
// Package: shared types for the octet slip buffer.
// Assumes octets are 8 bits wide; slip actions are chosen on the read side.
package osb_pkg;
    typedef logic [7:0] octet_t;

    typedef enum logic [1:0] {
        SLIP_REPEAT = 2'd0,
        SLIP_NORMAL = 2'd1,
        SLIP_DELETE = 2'd2
    } slip_e;
endpackage

// File: rtl/osb_wr_store.sv
// Module: write-side octet ring with a Gray-coded write pointer.
// Assumes DEPTH is a power of two. Octets are written unconditionally; the
// read side keeps the fill low enough that no unread slot is overwritten.
module osb_wr_store
    import osb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         wr_clk,
    input  logic                         wr_rst_n,
    input  logic                         wr_stb,
    input  octet_t                       wr_octet,
    input  logic [$clog2(DEPTH)-1:0]     rd_addr,
    output octet_t                       rd_data,
    output logic [$clog2(DEPTH):0]       wr_gray
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    octet_t          ring [DEPTH];
    logic [PW-1:0]   wbin;
    logic [PW-1:0]   wbin_nxt;

    // Next binary write pointer.
    always_comb begin
        wbin_nxt = wbin + PW'(1);
    end

    // Store incoming octets into the ring.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ring[i] <= 8'hFF;
            end
        end else if (wr_stb) begin
            ring[wbin[AW-1:0]] <= wr_octet;
        end
    end

    // Advance the binary and Gray write pointers together.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin    <= '0;
            wr_gray <= '0;
        end else if (wr_stb) begin
            wbin    <= wbin_nxt;
            wr_gray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Asynchronous read port; the address only points at settled entries.
    always_comb begin
        rd_data = ring[rd_addr];
    end
endmodule

// File: rtl/osb_gray_sync.sv
// Module: multi-stage synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock, so every
// sampled value is either the old or the new pointer.
module osb_gray_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture stage from the foreign domain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= '0;
                    else        stage[0] <= d_in;
                end
            end else begin : g_rest
                // Further stages for settling time.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[s] <= '0;
                    else        stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage[STAGES-1];
endmodule

// File: rtl/osb_rd_ctrl.sv
// Module: read-side slip controller.
// Works out the fill from the synchronized write pointer and, at slot start
// only, decides to repeat, take the oldest, or drop one and take the next.
// Assumes `start` is a single-cycle pulse from the serializer.
module osb_rd_ctrl
    import osb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       rd_clk,
    input  logic                       rd_rst_n,
    input  logic                       start,
    input  logic [$clog2(DEPTH):0]     wgray_sync,
    input  octet_t                     rd_data,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output octet_t                     oct_sel,
    output logic [$clog2(DEPTH):0]     rptr,
    output logic [$clog2(DEPTH):0]     fill
);
    localparam int AW      = $clog2(DEPTH);
    localparam int PW      = AW + 1;
    localparam int DEL_LVL = DEPTH - 1;

    logic [PW-1:0] wbin;
    octet_t        last_q;
    slip_e         action;

    // Gray-to-binary conversion of the synchronized write pointer.
    always_comb begin
        wbin[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wgray_sync[i];
        end
    end

    // Unread octet count and slip choice.
    always_comb begin
        fill = wbin - rptr;
        if (fill == '0)
            action = SLIP_REPEAT;
        else if (int'(fill) >= DEL_LVL)
            action = SLIP_DELETE;
        else
            action = SLIP_NORMAL;
    end

    // Ring address: the oldest entry, or the one after it on a delete.
    always_comb begin
        if (action == SLIP_DELETE)
            rd_addr = rptr[AW-1:0] + AW'(1);
        else
            rd_addr = rptr[AW-1:0];
    end

    // Octet handed to the serializer.
    always_comb begin
        if (action == SLIP_REPEAT)
            oct_sel = last_q;
        else
            oct_sel = rd_data;
    end

    // Pointer and repeat register update, only at slot start.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rptr   <= '0;
            last_q <= 8'hFF;
        end else if (start) begin
            last_q <= oct_sel;
            case (action)
                SLIP_NORMAL: rptr <= rptr + PW'(1);
                SLIP_DELETE: rptr <= rptr + PW'(2);
                default:     rptr <= rptr;
            endcase
        end
    end
endmodule

// File: rtl/osb_serializer.sv
// Module: time-slot selection and MSB-first serializer.
// Assumes the slot signals are synchronous to rd_clk. The output is a flop,
// so it changes only at clock edges and never glitches at slot boundaries.
module osb_serializer
    import osb_pkg::*;
(
    input  logic   rd_clk,
    input  logic   rd_rst_n,
    input  logic   ts_a,
    input  logic   ts_b,
    input  logic   ts_sel,
    input  octet_t oct_in,
    output logic   ts_now,
    output logic   start,
    output logic   ser_out
);
    logic       ts_q;
    octet_t     shreg;
    logic [2:0] remain;

    // Pick the framing slot signal.
    always_comb begin
        ts_now = ts_sel ? ts_a : ts_b;
        start  = ts_now & ~ts_q;
    end

    // Remember the selected slot level for edge detection.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) ts_q <= 1'b0;
        else           ts_q <= ts_now;
    end

    // Shift the octet out MSB first, idle high otherwise.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            ser_out <= 1'b1;
            shreg   <= 8'hFF;
            remain  <= '0;
        end else if (start) begin
            ser_out <= oct_in[7];
            shreg   <= {oct_in[6:0], 1'b1};
            remain  <= 3'd7;
        end else if (ts_now && remain != 3'd0) begin
            ser_out <= shreg[7];
            shreg   <= {shreg[6:0], 1'b1};
            remain  <= remain - 3'd1;
        end else begin
            ser_out <= 1'b1;
            remain  <= '0;
        end
    end
endmodule

// File: rtl/osb_top.sv
// Module: octet slip buffer top level.
// Write domain stores octets; a Gray pointer crosses into the read domain;
// the read side decides slips at slot start and serializes the octet.
// Assumes wr_clk and rd_clk are unrelated and each reset is synchronous.
module osb_top
    import osb_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_octet,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic       ts_a,
    input  logic       ts_b,
    input  logic       ts_sel,
    output logic       ser_out
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_gray;
    logic [PW-1:0] wr_gray_rd;
    logic [AW-1:0] rd_addr;
    octet_t        rd_data;
    octet_t        oct_sel;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] rd_fill;
    logic          ts_now;
    logic          slot_start;

    osb_wr_store #(.DEPTH(DEPTH)) u_store (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_stb   (wr_stb),
        .wr_octet (wr_octet),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_gray  (wr_gray)
    );

    osb_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (wr_gray),
        .d_out (wr_gray_rd)
    );

    osb_rd_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .start      (slot_start),
        .wgray_sync (wr_gray_rd),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .oct_sel    (oct_sel),
        .rptr       (rd_ptr),
        .fill       (rd_fill)
    );

    osb_serializer u_ser (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .ts_a     (ts_a),
        .ts_b     (ts_b),
        .ts_sel   (ts_sel),
        .oct_in   (oct_sel),
        .ts_now   (ts_now),
        .start    (slot_start),
        .ser_out  (ser_out)
    );
endmodule

// File: rtl/osb_checker.sv
// Module: assertion checker bound to osb_top.
// Observes the read pointer, fill, slot start, output and write Gray pointer.
module osb_checker #(
    parameter int DEPTH = 4
) (
    input logic                   rd_clk,
    input logic                   rd_rst_n,
    input logic                   wr_clk,
    input logic                   wr_rst_n,
    input logic                   start,
    input logic                   ts_now,
    input logic                   ser_out,
    input logic [$clog2(DEPTH):0] rptr,
    input logic [$clog2(DEPTH):0] fill,
    input logic [$clog2(DEPTH):0] wgray
);
    localparam int PW = $clog2(DEPTH) + 1;

    AST_IDLE_HIGH: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !ts_now |=> ser_out); // R2

    AST_HOLD_MIDSLOT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !start |=> $stable(rptr)); // R8

    AST_REPEAT_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (start && fill == '0) |=> $stable(rptr)); // R6

    AST_NORMAL_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (start && fill != '0 && int'(fill) < DEPTH - 1)
        |=> rptr == PW'($past(rptr) + PW'(1))); // R5

    AST_DELETE_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (start && int'(fill) >= DEPTH - 1)
        |=> rptr == PW'($past(rptr) + PW'(2))); // R7

    AST_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R9
endmodule

bind osb_top osb_checker #(.DEPTH(DEPTH)) u_chk (
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .start    (slot_start),
    .ts_now   (ts_now),
    .ser_out  (ser_out),
    .rptr     (rd_ptr),
    .fill     (rd_fill),
    .wgray    (wr_gray)
);

// File: tb/tb_osb_top.sv
module tb_osb_top;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_octet = 8'h00;
    logic       ts_a = 1'b0;
    logic       ts_b = 1'b0;
    logic       ts_sel = 1'b1;
    logic       ser_out;

    int total = 0;
    int bad   = 0;
    int seed  = 32'h5EED_0017;

    logic [7:0] hist [0:4095];
    int wcount = 0;
    int ridx   = 0;
    logic [7:0] last_exp = 8'hFF;
    int cycles = 0;

    always #5 rd_clk = ~rd_clk;   // 100 MHz read clock
    always #7 wr_clk = ~wr_clk;   // unrelated write clock

    osb_top dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_stb(wr_stb), .wr_octet(wr_octet),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .ts_a(ts_a), .ts_b(ts_b),
        .ts_sel(ts_sel), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Write one octet and record it in the bench history.
    task automatic put(input logic [7:0] v);
        @(negedge wr_clk);
        wr_stb   = 1'b1;
        wr_octet = v;
        hist[wcount] = v;
        wcount++;
        @(negedge wr_clk);
        wr_stb = 1'b0;
    endtask

    // Expected octet for the next slot; updates the model pointers.
    function automatic logic [7:0] next_exp();
        int f;
        logic [7:0] e;
        f = wcount - ridx;
        if (f == 0) begin
            e = last_exp;
        end else if (f >= 3) begin
            e = hist[ridx + 1];
            ridx += 2;
        end else begin
            e = hist[ridx];
            ridx += 1;
        end
        last_exp = e;
        return e;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    // Noise on the unselected slot line must not produce data (R4).
    task automatic noise_other(input logic sel);
        @(negedge rd_clk);
        ts_sel = sel;
        if (sel) ts_b = 1'b1; else ts_a = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge rd_clk);
            chk("R4 unselected line", {7'b0, ser_out}, 8'h01);
        end
        ts_a = 1'b0;
        ts_b = 1'b0;
        @(negedge rd_clk);
    endtask

    // One framed slot of 10 cycles; optional write during the slot (R8).
    task automatic slot(input logic sel, input logic [7:0] exp, input bit mid_wr,
                        input logic [7:0] mid_val);
        @(negedge rd_clk);
        ts_sel = sel;
        if (sel) ts_a = 1'b1; else ts_b = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (mid_wr && i == 3) begin
                fork
                    put(mid_val);
                join_none
            end
            @(negedge rd_clk);
            if (i < 8)
                chk(mid_wr ? "R8 bit during write" : "R3/R5 slot bit",
                    {7'b0, ser_out}, {7'b0, exp[7-i]});
            else
                chk("R3 trailing slot high", {7'b0, ser_out}, 8'h01);
        end
        ts_a = 1'b0;
        ts_b = 1'b0;
        @(negedge rd_clk);
        chk("R2 idle high", {7'b0, ser_out}, 8'h01);
    endtask

    // Watchdog.
    always @(posedge rd_clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] e;
        logic s;
        int n;
        void'($urandom(seed));
        idle(4);
        chk("R1 reset output", {7'b0, ser_out}, 8'h01);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        idle(3);
        chk("R1 output after reset", {7'b0, ser_out}, 8'h01);

        // R6 / R1: empty ring after reset repeats 8'hFF.
        e = next_exp();
        slot(1'b1, e, 1'b0, 8'h00);
        chk("R1 first empty slot octet", e, 8'hFF);

        // R5: one octet, normal read via ts_b.
        put(8'hA5);
        idle(6);
        slot(1'b0, next_exp(), 1'b0, 8'h00);

        // R6: nothing new, repeat of A5.
        e = next_exp();
        chk("R6 model repeat value", e, 8'hA5);
        slot(1'b1, e, 1'b0, 8'h00);

        // R7: three unread, oldest dropped.
        put(8'h11); put(8'h3C); put(8'hC3);
        idle(6);
        e = next_exp();
        chk("R7 model delete value", e, 8'h3C);
        slot(1'b1, e, 1'b0, 8'h00);
        slot(1'b0, next_exp(), 1'b0, 8'h00);

        // R8: empty ring, write arrives mid-slot; repeat must stay intact.
        e = next_exp();
        slot(1'b1, e, 1'b1, 8'h0F);
        idle(6);
        slot(1'b1, next_exp(), 1'b0, 8'h00);

        // R4: noise on the other line.
        noise_other(1'b1);
        noise_other(1'b0);
        slot(1'b0, next_exp(), 1'b0, 8'h00);

        // Random frames.
        for (int fr = 0; fr < 200; fr++) begin
            n = int'($urandom_range(0, 2));
            if (n > 3 - (wcount - ridx)) n = 3 - (wcount - ridx);
            for (int k = 0; k < n; k++) put(8'($urandom));
            idle(6);
            s = 1'($urandom);
            if ($urandom_range(0, 7) == 0) noise_other(s);
            slot(s, next_exp(), 1'b0, 8'h00);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule